// File: doc/BRIEF.md
# Capture Timer Channel with Sticky Event Flags

This block is one general-purpose timer channel. A 16-bit counter advances by one on every clock. A capture register takes a snapshot of the counter when a chosen edge appears on an asynchronous capture input. A reference register is compared against the counter. Two sticky event flags record a reference match and a capture. Software clears each flag by writing one to its bit. A single level interrupt request is raised from the flags whose interrupts are enabled.

Software reaches the channel over a simple single-cycle register bus. A write takes effect at the clock edge where it is presented. A read returns data combinationally in the same cycle. Writing the counter register always returns the counter to zero, whatever the data. Reading it has no side effect. The reference comparison can optionally restart the count, which gives a periodic time base. Without restart the counter runs through the full 16-bit range and wraps.

Top module: `capture_timer`

## Requirements
- R1: The counter resets to 0x0000 and increases by one on every clock edge. It wraps from 0xFFFF to 0x0000 when no restart applies.
- R2: A read of the counter register (address 3) returns the present count and has no effect on counting.
- R3: Any write to the counter register sets it to 0x0000 at that edge, whatever the written data.
- R4: The capture input passes through two flip-flops before edge detection. Mode bits [1:0] choose the capture edge: 00 off, 01 rising, 10 falling, 11 both. On a chosen edge, the capture register (address 2, reset 0, writes ignored) loads the count present in the detection cycle. With the input changed just before edge k, that is the count after edge k+1.
- R5: With the compare enable (mode bit 2) set, a count equal to the reference register (address 1) is a match. With restart (mode bit 5) set, the next count after a match is 0x0000; otherwise counting continues.
- R6: A match sets the reference flag and a capture sets the capture flag, whatever the interrupt enables are.
- R7: The event register (address 4) has the capture flag in bit 0 and the reference flag in bit 1, and reads zero in bits 15:2. Writing 1 to a bit clears that flag and writing 0 leaves it alone. Both flags can be cleared by one write.
- R8: If a flag's event and a write-one-to-clear of that flag fall in the same cycle, the flag ends up set.
- R9: The interrupt output is high while the reference flag is set with its enable (mode bit 3), or while the capture flag is set with its enable (mode bit 4). It stays high until every enabled flag is cleared.
- R10: The mode register (address 0) holds bits 5:0, reads back what was written with zeros above, and resets to zero. The reference register resets to zero and reads back its value. Other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Level interrupt request |

## Verification
A counter that is wrong shows up at the next counter read, and in the capture value, which is always set two edges after an input change, so an off-by-one in the synchronizer shows directly as a wrong captured number. A flag that fails to set, clear or hold shows up at the event register, and on the interrupt output, in the cycle after the edge that should have changed it. The tests place the capture event and the clearing write in the same cycle, and they clear one of two flags while watching the interrupt, so that a mistake in priority or in the merging of the flags becomes visible at the next read.

// File: rtl/cpt_pkg.sv
`timescale 1ns/1ps
package cpt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_REF  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_EVT  = 3'd4;

  localparam int EV_CAP = 0;
  localparam int EV_REF = 1;
  localparam int EV_N   = 2;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      restart;
    logic      cap_ie;
    logic      ref_ie;
    logic      cmp_en;
    edge_sel_e edge_sel;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  // Edge qualification from previous and current synchronized samples.
  function automatic logic edge_hit(edge_sel_e sel, logic prev, logic cur);
    case (sel)
      EDGE_RISE: return !prev && cur;
      EDGE_FALL: return prev && !cur;
      EDGE_ANY:  return prev ^ cur;
      default:   return 1'b0;
    endcase
  endfunction

  // Sticky flag update: a set beats a clear in the same cycle.
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/cpt_edge_detect.sv
`timescale 1ns/1ps
module cpt_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                din,
  input  cpt_pkg::edge_sel_e  sel,
  output logic                hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("cpt_edge_detect needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign cur = sync_q[STAGES-1];
  assign hit = cpt_pkg::edge_hit(sel, prev_q, cur);
endmodule

// File: rtl/cpt_counter.sv
`timescale 1ns/1ps
module cpt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         cmp_en,
  input  logic         restart,
  input  logic [W-1:0] refv,
  output logic [W-1:0] cnt,
  output logic         match
);
  function automatic logic [W-1:0] next_count(logic [W-1:0] cur, logic zero_now);
    return zero_now ? '0 : cur + W'(1);
  endfunction

  function automatic logic compare_hit(logic en, logic [W-1:0] a, logic [W-1:0] b);
    return en && (a == b);
  endfunction

  assign match = compare_hit(cmp_en, cnt, refv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_count(cnt, clr || (match && restart));
  end
endmodule

// File: rtl/cpt_event_flags.sv
`timescale 1ns/1ps
module cpt_event_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= 1'b0;
        else        f_q <= cpt_pkg::flag_next(f_q, set[i], clr[i]);
      end
      assign flags[i] = f_q;
    end
  endgenerate
endmodule

// File: rtl/capture_timer.sv
`timescale 1ns/1ps
module capture_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = cpt_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              cap_in,
  output logic              irq
);
  import cpt_pkg::*;

  localparam int EVN = EV_N;

  mode_t              mode_q;
  logic [CNT_W-1:0]   ref_q;
  logic [CNT_W-1:0]   cap_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [EVN-1:0]     ev_q;
  logic [EVN-1:0]     ev_set;
  logic [EVN-1:0]     ev_wr_mask;
  logic [EVN-1:0]     irq_src;

  // Named internal events (also observed by the checker)
  logic wr_any;
  logic cnt_clr;
  logic match_evt;
  logic cap_evt;
  logic restart_en;

  assign wr_any     = bus_en && bus_we;
  assign cnt_clr    = wr_any && (bus_addr == ADDR_W'(A_CNT));
  assign restart_en = mode_q.restart;

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
    end else if (wr_any) begin
      if (bus_addr == ADDR_W'(A_MODE)) mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
      if (bus_addr == ADDR_W'(A_REF))  ref_q  <= bus_wdata;
    end
  end

  cpt_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .cmp_en  (mode_q.cmp_en),
    .restart (mode_q.restart),
    .refv    (ref_q),
    .cnt     (cnt_q),
    .match   (match_evt)
  );

  cpt_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cap_in),
    .sel   (mode_q.edge_sel),
    .hit   (cap_evt)
  );

  // Capture register: loads the live count, ignores bus writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= '0;
    else if (cap_evt) cap_q <= cnt_q;
  end

  always_comb begin
    ev_set          = '0;
    ev_set[EV_CAP]  = cap_evt;
    ev_set[EV_REF]  = match_evt;
    ev_wr_mask      = (wr_any && (bus_addr == ADDR_W'(A_EVT))) ? bus_wdata[EVN-1:0] : '0;
  end

  cpt_event_flags #(.N(EVN)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ev_set),
    .clr   (ev_wr_mask),
    .flags (ev_q)
  );

  always_comb begin
    irq_src         = '0;
    irq_src[EV_CAP] = ev_q[EV_CAP] && mode_q.cap_ie;
    irq_src[EV_REF] = ev_q[EV_REF] && mode_q.ref_ie;
  end
  assign irq = |irq_src;

  // Read mux, combinational in the access cycle
  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr)
        ADDR_W'(A_MODE): bus_rdata = CNT_W'(mode_q);
        ADDR_W'(A_REF):  bus_rdata = ref_q;
        ADDR_W'(A_CAP):  bus_rdata = cap_q;
        ADDR_W'(A_CNT):  bus_rdata = cnt_q;
        ADDR_W'(A_EVT):  bus_rdata = CNT_W'(ev_q);
        default:         bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cpt_checker.sv
`timescale 1ns/1ps
module cpt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_clr,
  input logic         match_evt,
  input logic         cap_evt,
  input logic         restart_en,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] cap_q,
  input logic [1:0]   ev_q,
  input logic [1:0]   ev_wr_mask,
  input logic         irq
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && !(match_evt && restart_en)) |=> (cnt_q == $past(cnt_q) + W'(1)));

  assert_counter_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_q == '0));

  assert_capture_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(cnt_q)));

  assert_capture_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_q));

  assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && restart_en) |=> (cnt_q == '0));

  assert_ref_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> ev_q[1]);

  assert_cap_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> ev_q[0]);

  assert_cap_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_mask[0] && !cap_evt) |=> !ev_q[0]);

  assert_ref_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_mask[1] && !match_evt) |=> !ev_q[1]);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q[0] && !ev_wr_mask[0]) |=> ev_q[0]);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ev_q != 2'b00));

  assert_irq_low_when_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q == 2'b00) |-> !irq);
endmodule

bind capture_timer cpt_checker #(.W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_clr    (cnt_clr),
  .match_evt  (match_evt),
  .cap_evt    (cap_evt),
  .restart_en (restart_en),
  .cnt_q      (cnt_q),
  .cap_q      (cap_q),
  .ev_q       (ev_q),
  .ev_wr_mask (ev_wr_mask),
  .irq        (irq)
);

// File: tb/tb_capture_timer.sv
`timescale 1ns/1ps
module tb_capture_timer;
  localparam real CLK_PERIOD = 8.0;

  localparam logic [2:0] AM = 3'd0, AR = 3'd1, AC = 3'd2, AN = 3'd3, AE = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        cap_in;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_timer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cap_in    (cap_in),
    .irq       (irq)
  );

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input string what, input logic [2:0] a, input logic [15:0] exp);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    chk(req, what, bus_rdata, exp);
    bus_en = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R10", "mode after reset", AM, 16'h0000);
    rd_chk("R10", "ref after reset", AR, 16'h0000);
    rd_chk("R4", "capture after reset", AC, 16'h0000);
    rd_chk("R1", "counter in reset", AN, 16'h0000);
    rd_chk("R7", "events after reset", AE, 16'h0000);
    chk("R9", "irq after reset", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_count_read;
    wr(AN, 16'hFFFF);
    rd_chk("R3", "clear with all-ones data", AN, 16'h0000);
    wait_n(3);
    rd_chk("R1", "count after 3 edges", AN, 16'h0003);
    rd_chk("R2", "second read same cycle", AN, 16'h0003);
    wait_n(1);
    rd_chk("R2", "count continues after reads", AN, 16'h0004);
    wr(AR, 16'hA5A5);
    rd_chk("R10", "ref readback", AR, 16'hA5A5);
    wr(AM, 16'hFFC0);
    rd_chk("R10", "mode upper bits dropped", AM, 16'h0000);
    rd_chk("R10", "unused address reads zero", 3'd6, 16'h0000);
    wr(AC, 16'h1234);
    rd_chk("R4", "capture write ignored", AC, 16'h0000);
  endtask

  task automatic t_capture_rising;
    wr(AM, 16'h0001);
    wr(AN, 16'h0000);
    cap_in = 1'b1;
    wait_n(4);
    rd_chk("R4", "rising capture value", AC, 16'h0002);
    rd_chk("R6", "capture flag set", AE, 16'h0001);
    wr(AE, 16'h0001);
    cap_in = 1'b0;
    wait_n(4);
    rd_chk("R4", "falling ignored in rising mode", AE, 16'h0000);
  endtask

  task automatic t_capture_falling;
    wr(AM, 16'h0002);
    cap_in = 1'b1;
    wait_n(4);
    rd_chk("R4", "rising ignored in falling mode", AE, 16'h0000);
    wr(AN, 16'h0000);
    wait_n(3);
    cap_in = 1'b0;
    wait_n(4);
    rd_chk("R4", "falling capture value", AC, 16'h0005);
    rd_chk("R4", "falling capture flag", AE, 16'h0001);
    wr(AE, 16'h0001);
  endtask

  task automatic t_capture_both;
    wr(AM, 16'h0003);
    wr(AN, 16'h0000);
    wait_n(1);
    cap_in = 1'b1;
    wait_n(4);
    rd_chk("R4", "either edge, rising", AC, 16'h0003);
    wr(AE, 16'h0001);
    wr(AN, 16'h0000);
    cap_in = 1'b0;
    wait_n(4);
    rd_chk("R4", "either edge, falling", AC, 16'h0002);
    wr(AE, 16'h0001);
  endtask

  task automatic t_capture_off;
    wr(AM, 16'h0000);
    cap_in = 1'b1;
    wait_n(4);
    rd_chk("R4", "capture off: no flag", AE, 16'h0000);
    rd_chk("R4", "capture off: value kept", AC, 16'h0002);
  endtask

  task automatic t_ref_restart;
    wr(AR, 16'h0005);
    wr(AE, 16'h0003);
    wr(AN, 16'h0000);
    wr(AM, 16'h0024);
    wait_n(5);
    rd_chk("R5", "ref flag on match", AE, 16'h0002);
    rd_chk("R5", "restart to zero", AN, 16'h0000);
    chk("R6", "irq low, enables off", {15'd0, irq}, 16'h0000);
    wait_n(1);
    rd_chk("R5", "counting after restart", AN, 16'h0001);
  endtask

  task automatic t_ref_free;
    wr(AM, 16'h0000);
    wr(AE, 16'h0003);
    wr(AN, 16'h0000);
    wr(AM, 16'h0004);
    wait_n(5);
    rd_chk("R6", "ref flag without enable", AE, 16'h0002);
    rd_chk("R5", "no restart keeps counting", AN, 16'h0006);
  endtask

  task automatic t_w1c;
    wr(AM, 16'h0007);
    cap_in = 1'b0;
    wait_n(4);
    rd_chk("R7", "both flags set", AE, 16'h0003);
    wr(AE, 16'h0000);
    rd_chk("R7", "writing zero no effect", AE, 16'h0003);
    wr(AE, 16'h0002);
    rd_chk("R7", "clear ref bit only", AE, 16'h0001);
    wr(AE, 16'h0001);
    rd_chk("R7", "clear capture bit", AE, 16'h0000);
  endtask

  task automatic t_irq;
    wr(AM, 16'h0000);
    wr(AE, 16'h0003);
    wr(AN, 16'h0000);
    wr(AM, 16'h001F);
    wait_n(5);
    rd_chk("R9", "ref flag for irq", AE, 16'h0002);
    chk("R9", "irq from ref flag", {15'd0, irq}, 16'h0001);
    cap_in = 1'b1;
    wait_n(4);
    rd_chk("R9", "both flags", AE, 16'h0003);
    wr(AE, 16'h0002);
    chk("R9", "irq held by capture flag", {15'd0, irq}, 16'h0001);
    wr(AE, 16'h0001);
    chk("R9", "irq low once all clear", {15'd0, irq}, 16'h0000);
    wr(AN, 16'h0000);
    cap_in = 1'b0;
    wait_n(6);
    rd_chk("R9", "both flags again", AE, 16'h0003);
    chk("R9", "irq high again", {15'd0, irq}, 16'h0001);
    wr(AE, 16'h0003);
    rd_chk("R7", "both cleared in one write", AE, 16'h0000);
    chk("R9", "irq low after joint clear", {15'd0, irq}, 16'h0000);
    wr(AM, 16'h000B);
    cap_in = 1'b1;
    wait_n(4);
    rd_chk("R6", "capture flag with its enable off", AE, 16'h0001);
    chk("R9", "irq ignores disabled flag", {15'd0, irq}, 16'h0000);
    wr(AE, 16'h0001);
  endtask

  task automatic t_priority;
    wr(AM, 16'h0003);
    cap_in = 1'b0;
    wait_n(4);
    rd_chk("R8", "flag before collision", AE, 16'h0001);
    cap_in = 1'b1;
    wait_n(2);
    wr(AE, 16'h0001);
    rd_chk("R8", "set wins over clear", AE, 16'h0001);
    wr(AE, 16'h0001);
    rd_chk("R7", "clear after collision", AE, 16'h0000);
  endtask

  task automatic t_wrap;
    wr(AM, 16'h0000);
    wr(AN, 16'h0000);
    wait_n(65535);
    rd_chk("R1", "top of range", AN, 16'hFFFF);
    wait_n(1);
    rd_chk("R1", "wrap to zero", AN, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    cap_in = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    wait_n(2);
    t_count_read;
    t_capture_rising;
    t_capture_falling;
    t_capture_both;
    t_capture_off;
    t_ref_restart;
    t_ref_free;
    t_w1c;
    t_irq;
    t_priority;
    t_wrap;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule